// File: doc/BRIEF.md
# Single-Bus Accumulator Computer

This block is a complete, very small stored-program computer. A program counter, an address register, a constant 16-word by 8-bit program memory, an instruction register, an accumulator, an operand register, an adder-subtractor and a result register all exchange data over one shared 8-bit bus. The only inputs are a clock and a reset. The outputs are the result register and a flag that shows the machine has stopped.

The program and its data come from a parameter that holds the memory image. Because every transfer uses the same bus, each instruction runs as a fixed series of six timing steps. The first three steps fetch the instruction and the last three execute it. The block is used to run a short fixed calculation after reset and to present its answer on the result port.

Top module: `bus8_computer`

## Requirements
- R1: While reset is high and on the first clock after it, `result` is 0 and `halted` is 0. After reset is released, execution restarts from memory address 0.
- R2: Opcode 0000 (load) copies the memory word at the instruction's address into the accumulator.
- R3: Opcode 0001 (add) sets the accumulator to the accumulator plus the addressed memory word, modulo 256, with no flags.
- R4: Opcode 0010 (subtract) sets the accumulator to the accumulator minus the addressed memory word in two's complement, modulo 256.
- R5: Opcode 1110 (output) copies the accumulator to `result`. `result` changes at no other time except reset.
- R6: Every instruction takes exactly six clock cycles. For the instruction starting at cycle 6n after reset release, `result` and `halted` update on clock edge 6n+4, counting the first edge after release as edge 1.
- R7: Opcode 1111 (halt) sets `halted` on edge 6n+4 of that instruction. After that, `halted` stays 1 and `result` holds its value until reset.
- R8: Any other opcode (for example 0101) changes neither the accumulator nor `result`, and execution continues with the next word.
- R9: An instruction word carries the opcode in bits 7:4 and the operand address in bits 3:0. Instructions and data share the same 16-word memory.
- R10: The program counter advances by one per instruction and wraps from address 15 to address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| result | output | 8 | Value of the result register |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Nothing visible happens during the fetch steps, so the only points where outputs can change are the fourth edge of each six-cycle instruction. The bench runs a step-by-step model of the requirements next to each design instance. After every rising edge it compares `result` and `halted` at the following falling edge, so a value that arrives one edge early or late is reported. For the directed program, the bench also records the exact edge numbers at which `result` changes and `halted` rises, and compares them with 6n+4 for the instruction that causes the change. After each random mid-run reset, the same edge numbers must appear again, which shows that execution restarted from address 0.

// File: rtl/bus8_pkg.sv
package bus8_pkg;

    localparam int OP_W = 4;
    localparam int NT   = 6;

    localparam logic [OP_W-1:0] OP_LOAD = 4'h0;
    localparam logic [OP_W-1:0] OP_ADD  = 4'h1;
    localparam logic [OP_W-1:0] OP_SUB  = 4'h2;
    localparam logic [OP_W-1:0] OP_SHOW = 4'hE;
    localparam logic [OP_W-1:0] OP_STOP = 4'hF;

    // word 0 at the least significant byte
    localparam logic [127:0] DEMO_IMAGE = {
        8'h00, 8'h00, 8'h00, 8'h05, 8'h30, 8'h20, 8'hF0, 8'hF0,
        8'hE0, 8'h1C, 8'h50, 8'hE0, 8'h2B, 8'hE0, 8'h1A, 8'h09
    };

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_PC,
        SRC_MEM,
        SRC_IR,
        SRC_ACC,
        SRC_ALU
    } bus_src_e;

    typedef struct packed {
        bus_src_e src;
        logic     ld_mar;
        logic     ld_ir;
        logic     ld_acc;
        logic     ld_opr;
        logic     ld_res;
        logic     inc_pc;
        logic     sub;
        logic     stop;
    } ctrl_t;

    function automatic ctrl_t decode_step(logic [NT-1:0] step, logic [OP_W-1:0] op);
        ctrl_t c;
        c = '0;
        c.src = SRC_NONE;
        if (step[0]) begin
            c.src    = SRC_PC;
            c.ld_mar = 1'b1;
        end
        if (step[1]) begin
            c.inc_pc = 1'b1;
        end
        if (step[2]) begin
            c.src   = SRC_MEM;
            c.ld_ir = 1'b1;
        end
        if (step[3]) begin
            case (op)
                OP_LOAD, OP_ADD, OP_SUB: begin
                    c.src    = SRC_IR;
                    c.ld_mar = 1'b1;
                end
                OP_SHOW: begin
                    c.src    = SRC_ACC;
                    c.ld_res = 1'b1;
                end
                OP_STOP: c.stop = 1'b1;
                default: ;
            endcase
        end
        if (step[4]) begin
            case (op)
                OP_LOAD: begin
                    c.src    = SRC_MEM;
                    c.ld_acc = 1'b1;
                end
                OP_ADD, OP_SUB: begin
                    c.src    = SRC_MEM;
                    c.ld_opr = 1'b1;
                end
                default: ;
            endcase
        end
        if (step[5]) begin
            if (op == OP_ADD || op == OP_SUB) begin
                c.src    = SRC_ALU;
                c.ld_acc = 1'b1;
                c.sub    = (op == OP_SUB);
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/bus8_rom.sv
module bus8_rom #(
    parameter int DW    = 8,
    parameter int AW    = 4,
    parameter int DEPTH = 1 << AW,
    parameter logic [DW*DEPTH-1:0] IMAGE = '0
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    logic [DW-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign words[i] = IMAGE[i*DW +: DW];
    end

    assign data = words[addr];
endmodule

// File: rtl/bus8_addsub.sv
module bus8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] y
);
    logic [DW-1:0] b_eff;

    assign b_eff = b ^ {DW{sub}};
    assign y     = a + b_eff + {{(DW-1){1'b0}}, sub};
endmodule

// File: rtl/bus8_seq.sv
module bus8_seq
    import bus8_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output ctrl_t           ctrl,
    output logic            halted
);
    logic [NT-1:0] step;
    ctrl_t         raw;

    assign raw = decode_step(step, opcode);

    always_comb begin
        ctrl = raw;
        if (halted) begin
            ctrl     = '0;
            ctrl.src = SRC_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step   <= {{(NT-1){1'b0}}, 1'b1};
            halted <= 1'b0;
        end else if (!halted) begin
            if (ctrl.stop) begin
                halted <= 1'b1;
            end else begin
                step <= {step[NT-2:0], step[NT-1]};
            end
        end
    end

    // R6
    step_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(step) == 1);

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R7
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!ctrl.ld_acc && !ctrl.ld_res && !ctrl.inc_pc && !ctrl.ld_mar));
endmodule

// File: rtl/bus8_computer.sv
module bus8_computer
    import bus8_pkg::*;
#(
    parameter int AW = 4,
    parameter logic [(OP_W+AW)*(2**AW)-1:0] ROM_IMAGE = DEMO_IMAGE
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [OP_W+AW-1:0]   result,
    output logic                 halted
);
    localparam int DW    = OP_W + AW;
    localparam int DEPTH = 2 ** AW;

    ctrl_t         ctrl;
    logic [DW-1:0] bus;
    logic [AW-1:0] pc;
    logic [AW-1:0] mar;
    logic [DW-1:0] ir;
    logic [DW-1:0] acc;
    logic [DW-1:0] opr;
    logic [DW-1:0] res_q;
    logic [DW-1:0] mem_q;
    logic [DW-1:0] alu_y;

    bus8_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .opcode (ir[DW-1:AW]),
        .ctrl   (ctrl),
        .halted (halted)
    );

    bus8_rom #(
        .DW    (DW),
        .AW    (AW),
        .DEPTH (DEPTH),
        .IMAGE (ROM_IMAGE)
    ) u_rom (
        .addr (mar),
        .data (mem_q)
    );

    bus8_addsub #(
        .DW (DW)
    ) u_alu (
        .a   (acc),
        .b   (opr),
        .sub (ctrl.sub),
        .y   (alu_y)
    );

    always_comb begin
        case (ctrl.src)
            SRC_PC:  bus = {{OP_W{1'b0}}, pc};
            SRC_MEM: bus = mem_q;
            SRC_IR:  bus = {{OP_W{1'b0}}, ir[AW-1:0]};
            SRC_ACC: bus = acc;
            SRC_ALU: bus = alu_y;
            default: bus = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            mar   <= '0;
            ir    <= '0;
            acc   <= '0;
            opr   <= '0;
            res_q <= '0;
        end else begin
            if (ctrl.inc_pc) pc    <= pc + 1'b1;
            if (ctrl.ld_mar) mar   <= bus[AW-1:0];
            if (ctrl.ld_ir)  ir    <= bus;
            if (ctrl.ld_acc) acc   <= bus;
            if (ctrl.ld_opr) opr   <= bus;
            if (ctrl.ld_res) res_q <= bus;
        end
    end

    assign result = res_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc == '0 && acc == '0 && res_q == '0 && !halted));

    // R10
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.inc_pc |=> pc == $past(pc) + 1'b1);

    // R5
    res_copy_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.ld_res |=> res_q == $past(acc));

    // R3
    add_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.src == SRC_ALU && ctrl.ld_acc && !ctrl.sub) |=> acc == $past(acc) + $past(opr));

    // R4
    sub_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.src == SRC_ALU && ctrl.ld_acc && ctrl.sub) |=> acc == $past(acc) - $past(opr));

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(pc) && $stable(acc) && $stable(res_q)));
endmodule

// File: tb/bus8_computer_test.sv
`timescale 1ns/1ps
module bus8_computer_test;

    localparam int NI = 4;

    localparam logic [127:0] DIR_IMG = {
        8'h00, 8'h00, 8'h00, 8'h05, 8'h30, 8'h20, 8'hF0, 8'hF0,
        8'hE0, 8'h1C, 8'h50, 8'hE0, 8'h2B, 8'hE0, 8'h1A, 8'h09
    };

    function automatic logic [127:0] make_prog(int seed);
        logic [127:0] img;
        logic [31:0]  x;
        logic [7:0]   w;
        logic [3:0]   op;
        img = '0;
        x = 32'(seed) * 32'h9E3779B9 + 32'd1;
        for (int i = 0; i < 16; i++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            if (i >= 12) begin
                w = x[23:16];
            end else begin
                case (x[26:24])
                    3'd0, 3'd1: op = 4'h0;
                    3'd2, 3'd3: op = 4'h1;
                    3'd4:       op = 4'h2;
                    3'd5:       op = 4'hE;
                    3'd6:       op = 4'h7;
                    default:    op = 4'hF;
                endcase
                w = {op, x[19:16]};
            end
            if (seed == 3 && w[7:4] == 4'hF) w[7:4] = 4'hE;
            img[i*8 +: 8] = w;
        end
        return img;
    endfunction

    localparam logic [127:0] IMG1 = make_prog(1);
    localparam logic [127:0] IMG2 = make_prog(2);
    localparam logic [127:0] IMG3 = make_prog(3);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] outs [NI];
    logic       hlts [NI];

    always #2 clk = ~clk;

    bus8_computer #(.AW(4), .ROM_IMAGE(DIR_IMG)) uut (
        .clk(clk), .rst(rst), .result(outs[0]), .halted(hlts[0]));
    bus8_computer #(.AW(4), .ROM_IMAGE(IMG1)) rnd1 (
        .clk(clk), .rst(rst), .result(outs[1]), .halted(hlts[1]));
    bus8_computer #(.AW(4), .ROM_IMAGE(IMG2)) rnd2 (
        .clk(clk), .rst(rst), .result(outs[2]), .halted(hlts[2]));
    bus8_computer #(.AW(4), .ROM_IMAGE(IMG3)) rnd3 (
        .clk(clk), .rst(rst), .result(outs[3]), .halted(hlts[3]));

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    int         m_t   [NI];
    logic [3:0] m_pc  [NI];
    logic [3:0] m_mar [NI];
    logic [7:0] m_ir  [NI];
    logic [7:0] m_acc [NI];
    logic [7:0] m_b   [NI];
    logic [7:0] m_out [NI];
    bit         m_h   [NI];

    int         chg_edge [8];
    logic [7:0] chg_val  [8];
    int         n_chg;
    int         halt_edge;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_word(int k, logic [3:0] a);
        logic [127:0] img;
        case (k)
            0:       img = DIR_IMG;
            1:       img = IMG1;
            2:       img = IMG2;
            default: img = IMG3;
        endcase
        return img[int'(a)*8 +: 8];
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NI; k++) begin
            m_t[k] = 1; m_pc[k] = '0; m_mar[k] = '0; m_ir[k] = '0;
            m_acc[k] = '0; m_b[k] = '0; m_out[k] = '0; m_h[k] = 1'b0;
        end
    endtask

    task automatic model_step(int k);
        logic [3:0] op;
        if (m_h[k]) return;
        op = m_ir[k][7:4];
        case (m_t[k])
            1: m_mar[k] = m_pc[k];
            2: m_pc[k]  = m_pc[k] + 4'd1;
            3: m_ir[k]  = rom_word(k, m_mar[k]);
            4: begin
                if (op == 4'h0 || op == 4'h1 || op == 4'h2) m_mar[k] = m_ir[k][3:0];
                else if (op == 4'hE) m_out[k] = m_acc[k];
                else if (op == 4'hF) m_h[k] = 1'b1;
            end
            5: begin
                if (op == 4'h0) m_acc[k] = rom_word(k, m_mar[k]);
                else if (op == 4'h1 || op == 4'h2) m_b[k] = rom_word(k, m_mar[k]);
            end
            default: begin
                if (op == 4'h1) m_acc[k] = m_acc[k] + m_b[k];
                else if (op == 4'h2) m_acc[k] = m_acc[k] - m_b[k];
            end
        endcase
        if (!m_h[k]) m_t[k] = (m_t[k] == 6) ? 1 : m_t[k] + 1;
    endtask

    task automatic run_cycles(int n, bit record);
        logic [7:0] prev_out;
        bit         prev_h;
        prev_out = outs[0];
        prev_h   = hlts[0];
        for (int c = 1; c <= n; c++) begin
            @(posedge clk);
            @(negedge clk);
            for (int k = 0; k < NI; k++) begin
                model_step(k);
                // R5 (R10 on the program that never halts and wraps)
                chk(outs[k] == m_out[k], (k == 3) ? "R10" : "R5", outs[k], m_out[k]);
                // R7
                chk(hlts[k] == m_h[k], "R7", hlts[k], m_h[k]);
            end
            if (record) begin
                if (outs[0] != prev_out && n_chg < 8) begin
                    chg_edge[n_chg] = c;
                    chg_val[n_chg]  = outs[0];
                    n_chg++;
                end
                if (hlts[0] && !prev_h) halt_edge = c;
            end
            prev_out = outs[0];
            prev_h   = hlts[0];
        end
    endtask

    task automatic check_reset_state();
        for (int k = 0; k < NI; k++) begin
            // R1
            chk(outs[k] == 8'h00, "R1", outs[k], 0);
            chk(hlts[k] == 1'b0, "R1", hlts[k], 0);
        end
    endtask

    task automatic check_history();
        // R6 R9: three result updates, each on edge 6n+4 of its output instruction
        chk(n_chg == 3, "R6", n_chg, 3);
        // R3: 0xF0 + 0x20 wraps to 0x10, shown by instruction 2
        chk(chg_edge[0] == 16, "R6", chg_edge[0], 16);
        chk(chg_val[0] == 8'h10, "R3", chg_val[0], 8'h10);
        // R4: 0x10 - 0x30 = 0xE0, shown by instruction 4
        chk(chg_edge[1] == 28, "R6", chg_edge[1], 28);
        chk(chg_val[1] == 8'hE0, "R4", chg_val[1], 8'hE0);
        // R8 R2: opcode 0101 left the accumulator, then +5 gives 0xE5
        chk(chg_edge[2] == 46, "R8", chg_edge[2], 46);
        chk(chg_val[2] == 8'hE5, "R2", chg_val[2], 8'hE5);
        // R7: halt instruction 8 raises the flag on edge 52
        chk(halt_edge == 52, "R7", halt_edge, 52);
        chk(outs[0] == 8'hE5, "R7", outs[0], 8'hE5);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state();
        model_reset();
        n_chg = 0; halt_edge = -1;
        rst = 1'b0;
        run_cycles(100, 1'b1);
        check_history();
        for (int r = 0; r < 3; r++) begin
            run_cycles(int'($urandom_range(5, 60)), 1'b0);
            rst = 1'b1;
            repeat (int'($urandom_range(1, 4))) begin
                @(posedge clk);
                @(negedge clk);
                check_reset_state();
            end
            model_reset();
            n_chg = 0; halt_edge = -1;
            rst = 1'b0;
            run_cycles(110, 1'b1);
            check_history();
        end
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule